// File: doc/BRIEF.md
# Fine-Resolution PWM Generator

This block drives one pulse-width-modulated output from a fast clock. A prescaler divides the clock by four and advances an 8-bit period timer. The timer wraps when it reaches a programmable period value, so one output period lasts (period + 1) × 4 clocks. The prescaler phase is also used by the duty comparator. As a result, the high time is set to the nearest single clock instead of the nearest timer step. The duty value is 10 bits wide. It is held left-justified across a high byte and a low byte, which lets software use three forms. The first is the full 10-bit form. The second is an 8-bit high-resolution form with a short period. The third is an 8-bit low-resolution form with the low byte held at zero.

Software programs the block through a simple write port. Period and duty writes go to holding registers. The generator uses working copies of those values, and the copies are refreshed only when a period wraps or when software writes the control register. This means a change never produces a broken cycle. Every wrap sets a sticky event flag. Software clears the flag by writing a one, and the flag reaches the interrupt pin only when interrupts are enabled.

Top module: `fpwm_gen`

## Requirements
- R1: The output period is (P + 1) × 4 clocks, where P is the period register (address 1). The output goes high on the first clock of every period when the duty value is non-zero.
- R2: The output stays high for exactly D clocks from the start of each period, where D is the 10-bit duty value. The resolution is one clock, and the output is high while {timer, phase} < D.
- R3: The duty value is D = {high byte (address 2), bits 7:6 of the low byte (address 3)}. Bits 5:0 of the low byte are ignored.
- R4: With P = 8'h3F, an 8-bit value V written as high byte V>>2 and low byte (V&3)<<6 gives V clocks high in a 256-clock period.
- R5: With P = 8'hFF and the low byte at zero, an 8-bit value V in the high byte gives 4·V clocks high in a 1024-clock period.
- R6: Any write to the control register (address 0) restarts the timer and phase at zero and reloads the working period and duty copies. Bit 0 runs the timer and connects the output. While bit 0 is clear, the output is low and the timer holds.
- R7: Period and duty writes made during a running period do not change that period. They apply from the next wrap onward.
- R8: D = 0 holds the output low for the whole period. D ≥ (P + 1) × 4 holds it high for the whole period.
- R9: Each period wrap sets an event flag. The flag stays set until a write to address 4 with bit 0 set. If a set and a clear happen in the same cycle, the set wins.
- R10: The interrupt pin equals the event flag ANDed with control bit 1. Changing bit 1 does not change the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the prescaler and the duty resolution both use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index: 0 control, 1 period, 2 duty high, 3 duty low, 4 flag clear |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Period-wrap event flag, gated by the interrupt enable |

## Verification
The scoreboard measures the high-clock count over two consecutive periods for several configurations:
- a 10-bit duty with junk in the unused low bits, which separates the correct byte packing from a misaligned one;
- the 8-bit high- and low-resolution forms;
- a short 32-clock period with an odd duty, which shows single-clock resolution rather than four-clock steps;
- zero duty and an over-range duty, which exercise both saturation ends.

One case rewrites the period and duty in the middle of a period. In that case the first window must keep the old values and the second must follow the new ones, which separates shadowed loading from immediate loading. The interrupt pin is sampled on each side of the wrap. It is also sampled while the block is stopped, across enable changes and around a flag clear, to tell sticky gated behaviour apart from a level that follows the timer.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

   // register index map for the write port
   localparam int          FP_ADDR_W = 3;
   localparam logic [2:0]  A_CTRL    = 3'd0;
   localparam logic [2:0]  A_PER     = 3'd1;
   localparam logic [2:0]  A_DHI     = 3'd2;
   localparam logic [2:0]  A_DLO     = 3'd3;
   localparam logic [2:0]  A_CLR     = 3'd4;

   // bit positions inside the control and clear words
   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_IEN_BIT = 1;
   localparam int CLR_FLAG_BIT = 0;

endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs
   import fpwm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SUB_W  = 2,
   localparam int DUTY_W = DATA_W + SUB_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [FP_ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rollover,
   output logic                  run,
   output logic                  irq_en,
   output logic                  restart,
   output logic [DATA_W-1:0]     per_reg,
   output logic [DUTY_W-1:0]     duty_reg,
   output logic                  flag
);

   logic                 run_q, ien_q, flag_q;
   logic [DATA_W-1:0]    per_q, dhi_q;
   logic                 clr_wr;

   initial assert (DATA_W >= 2) else $fatal(1, "DATA_W too small");
   initial assert (SUB_W <= DATA_W) else $fatal(1, "SUB_W exceeds DATA_W");

   assign restart = wr_en && (wr_addr == A_CTRL);
   assign clr_wr  = wr_en && (wr_addr == A_CLR) && wr_data[CLR_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ien_q <= 1'b0;
         per_q <= '0;
         dhi_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: begin
               run_q <= wr_data[CTRL_RUN_BIT];
               ien_q <= wr_data[CTRL_IEN_BIT];
            end
            A_PER:   per_q <= wr_data;
            A_DHI:   dhi_q <= wr_data;
            default: ;
         endcase
      end
   end

   generate
      if (SUB_W > 0) begin : g_dlo
         logic [SUB_W-1:0] dlo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dlo_q <= '0;
            else if (wr_en && (wr_addr == A_DLO))
               dlo_q <= wr_data[DATA_W-1 -: SUB_W];
         end
         assign duty_reg = {dhi_q, dlo_q};
      end else begin : g_nodlo
         assign duty_reg = dhi_q;
      end
   endgenerate

   // sticky event flag, set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (rollover)
         flag_q <= 1'b1;
      else if (clr_wr)
         flag_q <= 1'b0;
   end

   assign run     = run_q;
   assign irq_en  = ien_q;
   assign per_reg = per_q;
   assign flag    = flag_q;

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |=> flag_q);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_wr) |=> flag_q);

endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int POS_W = TMR_W + SUB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [TMR_W-1:0]  per_reg,
   input  logic [POS_W-1:0]  duty_reg,
   output logic [POS_W-1:0]  pos,
   output logic [POS_W-1:0]  duty_sh,
   output logic              rollover
);

   logic [TMR_W-1:0] tmr_q, per_sh_q;
   logic [POS_W-1:0] duty_sh_q;
   logic             last_sub;
   logic             load;

   generate
      if (SUB_W > 0) begin : g_sub
         logic [SUB_W-1:0] sub_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sub_q <= '0;
            else if (restart)
               sub_q <= '0;
            else if (run)
               sub_q <= sub_q + 1'b1;
         end
         assign last_sub = &sub_q;
         assign pos      = {tmr_q, sub_q};
      end else begin : g_nosub
         assign last_sub = 1'b1;
         assign pos      = tmr_q;
      end
   endgenerate

   assign rollover = run && last_sub && (tmr_q == per_sh_q);
   assign load     = restart || rollover;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (restart || rollover)
         tmr_q <= '0;
      else if (run && last_sub)
         tmr_q <= tmr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh_q  <= '0;
         duty_sh_q <= '0;
      end else if (load) begin
         per_sh_q  <= per_reg;
         duty_sh_q <= duty_reg;
      end
   end

   assign duty_sh = duty_sh_q;

   // R1
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |=> (pos == '0));

   // R1
   tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_q <= per_sh_q);

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(duty_sh_q) && $stable(per_sh_q)));

endmodule

// File: rtl/fpwm_cmp.sv
module fpwm_cmp #(
   parameter int POS_W = 10
) (
   input  logic              run,
   input  logic [POS_W-1:0]  pos,
   input  logic [POS_W-1:0]  duty_sh,
   output logic              pwm
);

   initial assert (POS_W >= 1) else $fatal(1, "POS_W must be positive");

   always_comb begin
      pwm = 1'b0;
      if (run && (pos < duty_sh))
         pwm = 1'b1;
   end

endmodule

// File: rtl/fpwm_gen.sv
module fpwm_gen
   import fpwm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SUB_W  = 2,
   localparam int POS_W = DATA_W + SUB_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [FP_ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic                  pwm_out,
   output logic                  irq
);

   logic              run, irq_en, restart, flag, rollover;
   logic [DATA_W-1:0] per_reg;
   logic [POS_W-1:0]  duty_reg, duty_sh, pos;

   fpwm_regs #(.DATA_W(DATA_W), .SUB_W(SUB_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rollover (rollover),
      .run      (run),
      .irq_en   (irq_en),
      .restart  (restart),
      .per_reg  (per_reg),
      .duty_reg (duty_reg),
      .flag     (flag)
   );

   fpwm_timebase #(.TMR_W(DATA_W), .SUB_W(SUB_W)) tb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .restart  (restart),
      .per_reg  (per_reg),
      .duty_reg (duty_reg),
      .pos      (pos),
      .duty_sh  (duty_sh),
      .rollover (rollover)
   );

   fpwm_cmp #(.POS_W(POS_W)) cmp_i (
      .run     (run),
      .pos     (pos),
      .duty_sh (duty_sh),
      .pwm     (pwm_out)
   );

   assign irq = flag & irq_en;

   // R6
   stop_quiets_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == A_CTRL) && !wr_data[CTRL_RUN_BIT]) |=> !pwm_out);

   // R2
   fall_at_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwm_out) && run) |-> (pos == duty_sh));

endmodule

// File: tb/fpwm_gen_tb_top.sv
`timescale 1ns/1ps
module fpwm_gen_tb_top;

   typedef struct {
      string req;
      int    n1, h1, n2, h2;
      bit    ien;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out, irq;

   int    total = 0;
   int    failed = 0;
   item_t sb_q[$];
   bit    mon_busy = 1'b0;

   always #4 clk = ~clk;

   fpwm_gen dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_out (pwm_out),
      .irq     (irq)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   // driver: program, start, push the expected two-period item
   task automatic run_case(string req, int per, int dhi, int dlo, bit ien,
                           bit shadow, int per2, int dhi2, int dlo2);
      item_t it;
      int    d1, d2;
      wr(3'd0, {6'd0, ien, 1'b0});
      wr(3'd4, 8'h01);
      wr(3'd1, per[7:0]);
      wr(3'd2, dhi[7:0]);
      wr(3'd3, dlo[7:0]);
      d1     = dhi * 4 + (dlo >> 6);
      it.req = req;
      it.ien = ien;
      it.n1  = (per + 1) * 4;
      it.h1  = imin(d1, it.n1);
      if (shadow) begin
         d2    = dhi2 * 4 + (dlo2 >> 6);
         it.n2 = (per2 + 1) * 4;
         it.h2 = imin(d2, it.n2);
      end else begin
         it.n2 = it.n1;
         it.h2 = it.h1;
      end
      wr(3'd0, {6'd0, ien, 1'b1});
      sb_q.push_back(it);
      if (shadow) begin
         wr(3'd1, per2[7:0]);
         wr(3'd2, dhi2[7:0]);
         wr(3'd3, dlo2[7:0]);
      end
      wait (sb_q.size() == 0 && !mon_busy);
   endtask

   // monitor: measure two periods and compare against the item
   initial begin
      item_t it;
      int    c1, c2;
      forever begin
         wait (sb_q.size() > 0);
         mon_busy = 1'b1;
         it = sb_q.pop_front();
         c1 = 0;
         c2 = 0;
         for (int i = 0; i < it.n1; i++) begin
            @(negedge clk);
            if (i == 0) check({it.req, " R1 first clock"}, int'(pwm_out), int'(it.h1 > 0));
            if (pwm_out) c1++;
            if (i == it.n1 - 1) check({it.req, " R9 flag before wrap"}, int'(irq), 0);
         end
         for (int j = 0; j < it.n2; j++) begin
            @(negedge clk);
            if (j == 0) begin
               check({it.req, " R1 high after wrap"}, int'(pwm_out), int'(it.h2 > 0));
               check({it.req, " R9/R10 irq after wrap"}, int'(irq), int'(it.ien));
            end
            if (pwm_out) c2++;
         end
         check({it.req, " R2 high count period 1"}, c1, it.h1);
         check({it.req, " R2 high count period 2"}, c2, it.h2);
         mon_busy = 1'b0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      failed++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      int hc;
      repeat (3) @(negedge clk);
      check("R6 reset out", int'(pwm_out), 0);
      check("R10 reset irq", int'(irq), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 10-bit duty 679 with junk in low-byte bits 5:0
      run_case("R3 ten-bit", 8'hFF, 8'hA9, 8'hD5, 1'b1, 1'b0, 0, 0, 0);
      // R4 high-resolution 8-bit value 181
      run_case("R4 hires", 8'h3F, 45, 8'h40, 1'b1, 1'b0, 0, 0, 0);
      // R5 low-resolution 8-bit value 92
      run_case("R5 lores", 8'hFF, 8'h5C, 8'h00, 1'b1, 1'b0, 0, 0, 0);
      // R8 zero duty
      run_case("R8 zero", 8'h3F, 0, 0, 1'b1, 1'b0, 0, 0, 0);
      // R2 one-clock resolution: 13 clocks in 32
      run_case("R2 odd", 8'h07, 3, 8'h40, 1'b1, 1'b0, 0, 0, 0);
      // R7 duty 100 then 200, period 256 then 512
      run_case("R7 shadow", 8'h3F, 25, 0, 1'b1, 1'b1, 8'h7F, 50, 0);
      // R8 over-range duty 256 in 64-clock period
      run_case("R8 full", 8'h0F, 8'h40, 0, 1'b1, 1'b0, 0, 0, 0);

      // R6 stop: output low and held; R9 flag sticky
      wr(3'd0, 8'h02);
      hc = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (pwm_out) hc++;
      end
      check("R6 stopped high count", hc, 0);
      check("R9 flag sticky while stopped", int'(irq), 1);
      wr(3'd4, 8'h01);
      @(negedge clk);
      check("R9 flag cleared", int'(irq), 0);

      // R10 gating: flag set but enable off
      run_case("R10 gated", 8'h07, 4, 0, 1'b0, 1'b0, 0, 0, 0);
      wr(3'd0, 8'h00);
      @(negedge clk);
      check("R10 irq masked", int'(irq), 0);
      wr(3'd0, 8'h02);
      @(negedge clk);
      check("R10 irq after enable", int'(irq), 1);
      wr(3'd4, 8'h00);
      @(negedge clk);
      check("R9 clear needs bit0", int'(irq), 1);
      wr(3'd4, 8'h01);
      @(negedge clk);
      check("R9 clear with bit0", int'(irq), 0);

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule